// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synchronous single-port static memory with a shared data path that is split into a data input, a registered data output and an output-drive qualifier. A write presents its address, direction and lane enables on one clock edge. Its data arrives a fixed number of enabled edges later, and that delay equals the read latency. Because of this, a read may follow a write, and a write may follow a read, on consecutive cycles without any idle slot on the data path.

The read latency is two enabled edges in pipelined mode and one in flow-through mode. A held write buffer keeps the most recently supplied write data and moves it into the array only when the next write data arrives. Any read that targets the buffered address is served from the buffer one lane at a time. A load cycle may start a four-beat burst. Advance cycles then walk the low two address bits in interleaved or linear order and repeat the operation type of the load. An active-low clock enable freezes the whole block.

Top module: `lw_sram`

## Requirements
- R1: With `pipe_mode`=1, read data for a command sampled at enabled edge k is on `dout`, with `dout_en` high (when `oe_n`=0), from enabled edge k+2 until the next enabled edge.
- R2: With `pipe_mode`=0, the same holds one enabled edge after the command (edge k+1).
- R3: A write command at enabled edge k takes `din` at enabled edge k+2 (pipelined) or k+1 (flow-through). Lane i is `din[9i+8:9i]` and is written only when `lane_wr_n[i]`=0 at the command edge. Other lanes keep their old contents.
- R4: With `adv_ld`=0 the block loads `addr` and `rd_wr_n` (1 = read, 0 = write). It is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A load while unselected performs no access: its slot writes nothing and leaves `dout_en` low. Advance cycles after it stay idle.
- R5: With `adv_ld`=1 after a selected load, `addr`, `rd_wr_n` and the chip selects are ignored. The next burst beat repeats the loaded operation type, and for writes `lane_wr_n` is sampled afresh on every beat.
- R6: Beat n of a burst (n = 1..3, counted modulo 4) keeps the upper address bits. When `burst_ilv`=1 its low two bits are the loaded low bits XOR n. When `burst_ilv`=0 they are the loaded low bits plus n, modulo 4.
- R7: While `cke_n`=1, no command is accepted, no slot advances, and `dout`/`dout_en` hold their values.
- R8: `dout_en` is high only in a slot that carries read data and only while `oe_n`=0. `oe_n` gates `dout_en` without a clock and leaves `dout` unchanged. `dout_en` is low in every write-data slot.
- R9: A read of an address whose write data was supplied earlier but is still buffered returns that newest data, merged lane by lane with older array contents.
- R10: Reads and writes may alternate on every enabled edge with no idle cycles, and each read returns the value defined by all earlier writes.
- R11: After reset `dout_en` is low and no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (on load) |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| pipe_mode | input | 1 | 1 = two-edge latency, 0 = one-edge latency |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| din | input | LANE_W*LANES | Write data, taken in the write's data slot |
| dout | output | LANE_W*LANES | Registered read data |
| dout_en | output | 1 | High when `dout` should drive the shared bus |

## Verification
Every result of this block falls a fixed number of enabled edges after its command: two in pipelined mode and one in flow-through mode, for the read data on `dout` and for the write data taken from `din` alike. Stalled edges push that slot out by exactly the number of stalled cycles. The driver therefore indexes its expectations by enabled-edge count, not by wall-clock cycles. When it issues a command it files that command into the slot due L enabled edges later. When a slot falls due, the driver applies the write data or takes the expected read value from a shadow memory and queues one expected item for that edge. The monitor compares that item on the falling edge just after the rising edge that produced it, so each sample falls between the register update and the next input change.

// File: rtl/lw_pkg.sv
package lw_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    return ilv ? (start ^ step) : 2'(start + step);
  endfunction

endpackage

// File: rtl/lw_cmd_ctl.sv
module lw_cmd_ctl
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic              cs_ok,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be_n,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be
);

  localparam int HI_LSB = 2;

  logic              act_q, act_d;
  op_e               kind_q, kind_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;

  assign cmd_be = ~be_n;

  always_comb begin
    act_d    = act_q;
    kind_d   = kind_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    cmd_op   = OP_NONE;
    cmd_addr = base_q;
    if (!adv_ld) begin
      if (cs_ok) begin
        act_d    = 1'b1;
        kind_d   = rd_wr_n ? OP_RD : OP_WR;
        base_d   = addr;
        cnt_d    = 2'd0;
        cmd_op   = kind_d;
        cmd_addr = addr;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      cnt_d    = 2'(cnt_q + 2'd1);
      cmd_op   = kind_q;
      cmd_addr = {base_q[ADDR_W-1:HI_LSB], burst_lo(base_q[1:0], cnt_d, burst_ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      kind_q <= OP_NONE;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (!cke_n) begin
      act_q  <= act_d;
      kind_q <= kind_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: advance keeps base and operation type of the load
  a_r5_burst_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld && act_q) |=> (act_q && $stable(base_q) && $stable(kind_q)));

  // R4: unselected load leaves the burst idle
  a_r4_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !cs_ok) |=> !act_q);

endmodule

// File: rtl/lw_op_pipe.sv
module lw_op_pipe
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              pipe_mode,
  input  op_e               cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  output op_e               due_op,
  output logic [ADDR_W-1:0] due_addr,
  output logic [LANES-1:0]  due_be
);

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      s2_op   <= OP_NONE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
    end else if (!cke_n) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= cmd_be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  always_comb begin
    if (pipe_mode) begin
      due_op   = s2_op;
      due_addr = s2_addr;
      due_be   = s2_be;
    end else begin
      due_op   = s1_op;
      due_addr = s1_addr;
      due_be   = s1_be;
    end
  end

  // R7: a masked clock freezes every slot
  a_r7_slots_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)));

  // R1: second slot is the first slot one enabled edge later
  a_r1_slot_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_n |=> (s2_op == $past(s1_op) && s2_addr == $past(s1_addr)));

endmodule

// File: rtl/lw_store.sv
module lw_store
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  op_e                     due_op,
  input  logic [ADDR_W-1:0]       due_addr,
  input  logic [LANES-1:0]        due_be,
  input  logic [LANE_W*LANES-1:0] din,
  output logic [LANE_W*LANES-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANE_W * LANES;

  logic              wb_vld, wb_vld_d;
  logic [ADDR_W-1:0] wb_addr, wb_addr_d;
  logic [LANES-1:0]  wb_be, wb_be_d;
  logic [DATA_W-1:0] wb_data, wb_data_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              drv_q, drv_d;
  logic [DATA_W-1:0] fwd;
  logic              commit;

  assign commit = !cke_n && (due_op == OP_WR) && wb_vld;

  for (genvar g = 0; g < LANES; g++) begin : gen_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && wb_be[g]) mem[wb_addr] <= wb_data[g*LANE_W +: LANE_W];
    end

    assign fwd[g*LANE_W +: LANE_W] =
      (wb_vld && wb_be[g] && (wb_addr == due_addr)) ? wb_data[g*LANE_W +: LANE_W]
                                                    : mem[due_addr];
  end

  always_comb begin
    wb_vld_d  = wb_vld;
    wb_addr_d = wb_addr;
    wb_be_d   = wb_be;
    wb_data_d = wb_data;
    rd_d      = rd_q;
    drv_d     = 1'b0;
    unique case (due_op)
      OP_WR: begin
        wb_vld_d  = 1'b1;
        wb_addr_d = due_addr;
        wb_be_d   = due_be;
        wb_data_d = din;
      end
      OP_RD: begin
        rd_d  = fwd;
        drv_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld  <= 1'b0;
      wb_addr <= '0;
      wb_be   <= '0;
      wb_data <= '0;
      rd_q    <= '0;
      drv_q   <= 1'b0;
    end else if (!cke_n) begin
      wb_vld  <= wb_vld_d;
      wb_addr <= wb_addr_d;
      wb_be   <= wb_be_d;
      wb_data <= wb_data_d;
      rd_q    <= rd_d;
      drv_q   <= drv_d;
    end
  end

  assign rd_data  = rd_q;
  assign rd_drive = drv_q;

  // R8: a write-data slot never drives
  a_r8_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && due_op == OP_WR) |=> !drv_q);

  // R9: captured write data sits in the buffer for forwarding
  a_r9_wbuf_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && due_op == OP_WR) |=> (wb_vld && wb_addr == $past(due_addr)));

  // R7: outputs hold while the clock is masked
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rd_q) && $stable(drv_q)));

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              adv_ld,
  input  logic              rd_wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              burst_ilv,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              cs_ok;
  op_e               cmd_op, due_op;
  logic [ADDR_W-1:0] cmd_addr, due_addr;
  logic [LANES-1:0]  cmd_be, due_be;
  logic              rd_drive;

  assign cs_ok = !cs_a_n && cs_b && !cs_c_n;

  lw_cmd_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .adv_ld    (adv_ld),
    .rd_wr_n   (rd_wr_n),
    .cs_ok     (cs_ok),
    .burst_ilv (burst_ilv),
    .addr      (addr),
    .be_n      (lane_wr_n),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be)
  );

  lw_op_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .pipe_mode (pipe_mode),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be),
    .due_op    (due_op),
    .due_addr  (due_addr),
    .due_be    (due_be)
  );

  lw_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .due_op   (due_op),
    .due_addr (due_addr),
    .due_be   (due_be),
    .din      (din),
    .rd_data  (dout),
    .rd_drive (rd_drive)
  );

  assign dout_en = rd_drive && !oe_n;

  // R11: nothing drives in the first cycle after reset release
  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_drive);

endmodule

// File: tb/lw_sram_tb.sv
module lw_sram_tb;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke_n, cs_a_n, cs_b, cs_c_n, adv_ld, rd_wr_n;
  logic [1:0]    lane_wr_n;
  logic          burst_ilv, pipe_mode, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  lw_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .lane_wr_n(lane_wr_n),
    .burst_ilv(burst_ilv), .pipe_mode(pipe_mode), .oe_n(oe_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit            drv;
    logic [DW-1:0] data;
    string         tag;
  } item_t;

  item_t         exp_q[$];
  item_t         last_item;
  int            n_checks = 0;
  int            n_fail   = 0;

  // bench model state
  logic [DW-1:0] shadow [64];
  int            s_kind [4];
  logic [AW-1:0] s_addr [4];
  logic [1:0]    s_ben  [4];
  logic [DW-1:0] s_wd   [4];
  string         s_tag  [4];
  int            tick;
  int            lat;
  bit            b_act;
  int            b_kind;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  int            desel_k;
  bit            oe_v;

  // monitor: one queued expectation per rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      bit    en_exp;
      it = exp_q.pop_front();
      en_exp = it.drv && !oe_n;
      n_checks++;
      if (dout_en !== en_exp) begin
        n_fail++;
        $display("FAIL %s: dout_en got %0b expected %0b", it.tag, dout_en, en_exp);
      end
      if (it.drv) begin
        n_checks++;
        if (dout !== it.data) begin
          n_fail++;
          $display("FAIL %s: dout got %h expected %h", it.tag, dout, it.data);
        end
      end
    end
  end

  task automatic drive(input bit ck, input bit adv, input bit rw, input bit sel,
                       input logic [AW-1:0] a, input logic [1:0] ben,
                       input logic [DW-1:0] wd, input string tag);
    item_t it;
    @(negedge clk); #1;
    cke_n     = ck;
    adv_ld    = adv;
    rd_wr_n   = rw;
    addr      = a;
    lane_wr_n = ben;
    oe_n      = oe_v;
    cs_a_n    = sel ? 1'b0 : (desel_k == 0);
    cs_b      = sel ? 1'b1 : (desel_k != 1);
    cs_c_n    = sel ? 1'b0 : (desel_k == 2);
    if (!sel) desel_k = (desel_k + 1) % 3;
    din       = 18'h2AAAA ^ DW'(tick * 977);
    if (ck) begin
      it = last_item;
      it.tag = "R7";
    end else begin
      int nk;
      logic [AW-1:0] na;
      int di, ni;
      nk = 0;
      na = '0;
      if (!adv) begin
        if (sel) begin
          b_act = 1'b1; b_kind = rw ? 1 : 2; b_base = a; b_cnt = 2'd0;
          nk = b_kind; na = a;
        end else b_act = 1'b0;
      end else if (b_act) begin
        b_cnt = b_cnt + 2'd1;
        nk = b_kind;
        na = {b_base[AW-1:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : 2'(b_base[1:0] + b_cnt)};
      end
      di = tick % 4;
      it.drv = 1'b0; it.data = '0; it.tag = s_tag[di];
      if (s_kind[di] == 2) begin
        din = s_wd[di];
        for (int i = 0; i < 2; i++)
          if (!s_ben[di][i]) shadow[s_addr[di]][i*9 +: 9] = s_wd[di][i*9 +: 9];
      end else if (s_kind[di] == 1) begin
        it.drv  = 1'b1;
        it.data = shadow[s_addr[di]];
      end
      s_kind[di] = 0;
      ni = (tick + lat) % 4;
      s_kind[ni] = nk; s_addr[ni] = na; s_ben[ni] = ben; s_wd[ni] = wd; s_tag[ni] = tag;
      tick++;
    end
    exp_q.push_back(it);
    last_item = it;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] ben,
                    input logic [DW-1:0] wd, input string tag);
    drive(0, 0, 0, 1, a, ben, wd, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    drive(0, 0, 1, 1, a, 2'b00, '0, tag);
  endtask
  task automatic adv(input logic [1:0] ben, input logic [DW-1:0] wd, input string tag);
    // garbage on addr, rd_wr_n and selects: must be ignored
    drive(0, 1, tick[0], tick[1], ~b_base, ben, wd, tag);
  endtask
  task automatic nop(input string tag);
    drive(0, 0, 1, 0, 6'h3F, 2'b00, '0, tag);
  endtask
  task automatic stall();
    drive(1, 0, 0, 1, 6'h11, 2'b00, 18'h3FFFF, "R7");
  endtask

  task automatic reset_dut(input bit pm, input bit ilv);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk); #1;
    rst_n = 1'b0; pipe_mode = pm; burst_ilv = ilv; cke_n = 1'b0;
    adv_ld = 1'b0; rd_wr_n = 1'b1; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
    lane_wr_n = 2'b11; oe_v = 1'b0; oe_n = 1'b0; addr = '0; din = '0;
    lat = pm ? 2 : 1;
    tick = 0; b_act = 1'b0; b_kind = 0; b_base = '0; b_cnt = 2'd0;
    for (int i = 0; i < 4; i++) begin s_kind[i] = 0; s_tag[i] = "R11"; end
    last_item.drv = 1'b0; last_item.data = '0; last_item.tag = "R11";
    repeat (3) @(negedge clk);
    n_checks++;
    if (dout_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: dout_en in reset got %0b expected 0", dout_en);
    end
    #1 rst_n = 1'b1;
  endtask

  task automatic phase(input bit pm, input bit ilv);
    string lt;
    lt = pm ? "R1" : "R2";
    reset_dut(pm, ilv);
    repeat (3) nop("R11");
    for (int a = 0; a < 64; a++) wr(6'(a), 2'b00, DW'(a * 1371 + pm * 7 + 5), "R10");
    for (int i = 0; i < 8; i++) begin
      rd(6'(i), lt);
      wr(6'(i + 8), 2'b00, DW'(i * 4099 + 11), "R10");
    end
    for (int i = 0; i < 8; i++) rd(6'(i + 8), "R10");
    wr(6'd20, 2'b10, 18'h15A5A, "R9");
    rd(6'd20, "R9");
    wr(6'd21, 2'b01, 18'h0F0F0, "R3");
    wr(6'd21, 2'b11, 18'h3FFFF, "R3");
    nop("R3");
    rd(6'd21, "R3");
    rd(6'd6, "R6");
    repeat (3) adv(2'b00, '0, "R6");
    wr(6'd33, 2'b00, 18'h12345, "R5");
    adv(2'b01, 18'h2BCDE, "R5");
    adv(2'b10, 18'h0AAAA, "R5");
    adv(2'b11, 18'h3FFFF, "R5");
    for (int i = 32; i < 36; i++) rd(6'(i), "R5");
    drive(0, 0, 0, 0, 6'd40, 2'b00, 18'h00001, "R4");
    adv(2'b00, 18'h00002, "R4");
    rd(6'd40, "R4");
    rd(6'd1, "R7");
    rd(6'd2, "R7");
    repeat (3) stall();
    rd(6'd3, "R7");
    stall();
    nop("R7");
    oe_v = 1'b1;
    rd(6'd5, "R8");
    rd(6'd6, "R8");
    nop("R8");
    nop("R8");
    oe_v = 1'b0;
    repeat (4) nop("R8");
  endtask

  initial begin
    desel_k = 0;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    phase(1'b1, 1'b1);
    phase(1'b0, 1'b0);
    phase(1'b1, 1'b0);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule